// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a bus requester and backing memory. It answers a pair of 32 MiB alias windows in which every 32-bit word stands for a single bit of backing memory. A read of an alias word fetches the backing data that holds that bit and returns the bit alone. A write to an alias word performs a read-modify-write on the backing memory. The backing data is read first. The chosen bit is then forced to write-data bit 0, and the data is written back with every other bit unchanged.

Both ports are valid/ready streams. A request is taken on a rising clock edge where `s_req_valid` and `s_req_ready` are both high. `s_req_ready` is high only while no alias transaction is in progress, so exactly one transaction is in flight. The response is held, with its value unchanged, from the rise of `s_rsp_valid` until a clock edge sees `s_rsp_ready` high. The backing request is held stable in the same way until `m_req_ready` is high. The backing response has no ready: the bridge accepts `m_rsp_valid` in any cycle while it waits for one. Data on both ports is little-endian: the byte at the lowest address sits in bits 7:0. The size field carries the access size as a byte count.

Top module: `bitband_bridge`

## Requirements
- R1: An alias address whose bits 31:25 equal 0x11 belongs to the window backed at 0x2000_0000. Bits 31:25 equal to 0x21 select the window backed at 0x4000_0000. With offset = address AND 0x01FF_FFFF, the backing byte address is the window's backing base ORed with (offset >> 5).
- R2: The backing access uses the requester's size, and its address is the R1 address aligned down to a multiple of that size. The same address and size are used for both halves of a read-modify-write.
- R3: The bit index is (offset >> 2) AND (size*8 - 1). Index bits above 2 select the byte lane and index bits 2:0 select the bit within that byte. A read response carries that bit of the backing data in bit 0, with every other bit zero and the error flag low.
- R4: A write issues a backing read followed by a backing write at the same address and size. The write sets the selected bit when write-data bit 0 is 1 and clears it when it is 0. All other bits of the backing data are written back unchanged. The alias write response has rdata zero.
- R5: When the backing read reports an error, the alias response reports an error with rdata zero. For a write, no backing write follows.
- R6: When the backing write of a read-modify-write reports an error, the alias write response reports an error.
- R7: A size other than 1, 2 or 4 bytes, or an address outside both windows, gives an error response with rdata zero and makes no backing access.
- R8: While `enable` is low, every request gives an error response with rdata zero and makes no backing access.
- R9: Out of reset the bridge is ready, with no response pending and no backing request. `s_req_ready` stays low from the request handshake until the response handshake. While not accepted, the response and the backing request hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Alias decoding on when high |
| s_req_valid | input | 1 | Alias request valid |
| s_req_ready | output | 1 | Alias request accepted when high with valid |
| s_req_addr | input | 32 | Alias byte address |
| s_req_size | input | 3 | Access size in bytes |
| s_req_we | input | 1 | 1 = write, 0 = read |
| s_req_wdata | input | 32 | Write data; only bit 0 is used |
| s_rsp_valid | output | 1 | Alias response valid |
| s_rsp_ready | input | 1 | Requester takes response |
| s_rsp_rdata | output | 32 | Read result, selected bit in bit 0 |
| s_rsp_err | output | 1 | Error response |
| m_req_valid | output | 1 | Backing request valid |
| m_req_ready | input | 1 | Backing memory accepts request |
| m_req_addr | output | 32 | Backing byte address, size-aligned |
| m_req_size | output | 3 | Backing access size in bytes |
| m_req_we | output | 1 | Backing write when high |
| m_req_wdata | output | 32 | Backing write data, little-endian lanes |
| m_rsp_valid | input | 1 | Backing response valid |
| m_rsp_rdata | input | 32 | Backing read data, little-endian lanes |
| m_rsp_err | input | 1 | Backing access error |

## Verification
Several rules are checked in every cycle. Handshake hold is checked on both streams. The slave port must stay not-ready while a backing request is open. Every backing request must carry a legal size and an aligned address. A read response must have zero above bit 0. After a failed backing read, no request may follow. Only the bench scenarios can show that the address arithmetic, the byte-lane and bit choice, and the preserved neighbour bits are correct. They do this against an independent memory model, with injected backing errors, back-pressure on both sides, illegal sizes, addresses outside the windows and the disabled state.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int SIZE_W = 3;
  // one alias word per backing bit: 8 bits per byte, 4 alias bytes per word
  localparam int ALIAS_SHIFT = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  function automatic logic size_is_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode import bb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LOG2 = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000},
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              hit,
  output logic              size_ok,
  output logic [ADDR_W-1:0] baddr,
  output logic [BIT_W-1:0]  bitpos
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;

  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  sel_base;
  logic [ADDR_W-1:0]  off_ext;
  logic [ADDR_W-1:0]  raw_addr;
  logic [BIT_W:0]     lane_bits;
  logic [BIT_W-1:0]   lane_mask;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g] = (addr[ADDR_W-1:WIN_LOG2] ==
                         ALIAS_BASES[g*ADDR_W+WIN_LOG2 +: TAG_W]);
  end

  // lowest-numbered window wins if parameters ever overlap
  always_comb begin
    sel_base = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) sel_base = BACK_BASES[i*ADDR_W +: ADDR_W];
    end
  end

  assign hit      = |win_hit;
  assign size_ok  = size_is_legal(size) && (int'(size) <= DATA_W / 8);
  assign off_ext  = ADDR_W'(addr[WIN_LOG2-1:0]);
  assign raw_addr = sel_base | (off_ext >> ALIAS_SHIFT);
  assign baddr    = raw_addr & ~(ADDR_W'(size) - ADDR_W'(1));

  assign lane_bits = (BIT_W+1)'(size) << 3;
  assign lane_mask = BIT_W'(lane_bits - (BIT_W+1)'(1));
  assign bitpos    = addr[BIT_W+1:2] & lane_mask;
endmodule

// File: rtl/bb_bitlane.sv
module bb_bitlane #(
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [BIT_W-1:0]  bitpos,
  input  logic              set_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] word_out
);
  // little-endian lanes: index = 8*byte + bit maps straight onto the word
  always_comb begin
    word_out         = word_in;
    word_out[bitpos] = set_val;
  end
  assign bit_out = word_in[bitpos];
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl import bb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic              s_req_we,
  input  logic              s_req_wbit,
  input  logic              acc_ok,
  input  logic [ADDR_W-1:0] dec_baddr,
  input  logic [SIZE_W-1:0] dec_size,
  input  logic [BIT_W-1:0]  dec_bitpos,
  output logic              s_rsp_valid,
  input  logic              s_rsp_ready,
  output logic [DATA_W-1:0] s_rsp_rdata,
  output logic              s_rsp_err,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [SIZE_W-1:0] m_req_size,
  output logic              m_req_we,
  output logic [DATA_W-1:0] m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic              m_rsp_err,
  input  logic              lane_bit,
  input  logic [DATA_W-1:0] lane_word,
  output logic [BIT_W-1:0]  bitpos_q,
  output logic              wbit_q
);
  bb_state_e         state;
  logic              we_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      we_q       <= 1'b0;
      wbit_q     <= 1'b0;
      baddr_q    <= '0;
      size_q     <= '0;
      bitpos_q   <= '0;
      wdata_q    <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (s_req_valid) begin
            we_q     <= s_req_we;
            wbit_q   <= s_req_wbit;
            baddr_q  <= dec_baddr;
            size_q   <= dec_size;
            bitpos_q <= dec_bitpos;
            if (acc_ok) begin
              state <= ST_RD_REQ;
            end else begin
              rsp_err_q  <= 1'b1;
              rsp_data_q <= '0;
              state      <= ST_RESP;
            end
          end
        end
        ST_RD_REQ: if (m_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (m_rsp_valid) begin
            if (m_rsp_err) begin
              rsp_err_q  <= 1'b1;
              rsp_data_q <= '0;
              state      <= ST_RESP;
            end else if (we_q) begin
              wdata_q <= lane_word;
              state   <= ST_WR_REQ;
            end else begin
              rsp_err_q  <= 1'b0;
              rsp_data_q <= DATA_W'(lane_bit);
              state      <= ST_RESP;
            end
          end
        end
        ST_WR_REQ: if (m_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (m_rsp_valid) begin
            rsp_err_q  <= m_rsp_err;
            rsp_data_q <= '0;
            state      <= ST_RESP;
          end
        end
        ST_RESP: if (s_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_req_ready = (state == ST_IDLE);
  assign s_rsp_valid = (state == ST_RESP);
  assign s_rsp_rdata = rsp_data_q;
  assign s_rsp_err   = rsp_err_q;
  assign m_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign m_req_we    = (state == ST_WR_REQ);
  assign m_req_addr  = baddr_q;
  assign m_req_size  = size_q;
  assign m_req_wdata = (state == ST_WR_REQ) ? wdata_q : '0;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rsp_valid && !s_rsp_ready) |=> (s_rsp_valid && $stable(s_rsp_rdata) && $stable(s_rsp_err)));
  // R9
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr) &&
                                      $stable(m_req_size) && $stable(m_req_we)));
  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_ready |-> !(m_req_valid || s_rsp_valid));
  // R7
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid |-> size_is_legal(m_req_size));
  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid |-> ((m_req_addr & (ADDR_W'(m_req_size) - ADDR_W'(1))) == '0));
  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |-> (s_rsp_rdata[DATA_W-1:1] == '0));
  // R5
  no_write_after_rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_WAIT && m_rsp_valid && m_rsp_err) |=> !m_req_valid);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge import bb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LOG2 = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              s_req_valid,
  output logic              s_req_ready,
  input  logic [ADDR_W-1:0] s_req_addr,
  input  logic [SIZE_W-1:0] s_req_size,
  input  logic              s_req_we,
  input  logic [DATA_W-1:0] s_req_wdata,
  output logic              s_rsp_valid,
  input  logic              s_rsp_ready,
  output logic [DATA_W-1:0] s_rsp_rdata,
  output logic              s_rsp_err,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [SIZE_W-1:0] m_req_size,
  output logic              m_req_we,
  output logic [DATA_W-1:0] m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic [DATA_W-1:0] m_rsp_rdata,
  input  logic              m_rsp_err
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              dec_hit;
  logic              dec_size_ok;
  logic [ADDR_W-1:0] dec_baddr;
  logic [BIT_W-1:0]  dec_bitpos;
  logic              acc_ok;
  logic [BIT_W-1:0]  bitpos_q;
  logic              wbit_q;
  logic              lane_bit;
  logic [DATA_W-1:0] lane_word;

  bb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .NUM_WIN(NUM_WIN),
    .ALIAS_BASES(ALIAS_BASES), .BACK_BASES(BACK_BASES)
  ) u_decode (
    .addr(s_req_addr), .size(s_req_size), .hit(dec_hit), .size_ok(dec_size_ok),
    .baddr(dec_baddr), .bitpos(dec_bitpos)
  );

  assign acc_ok = enable && dec_hit && dec_size_ok;

  bb_bitlane #(.DATA_W(DATA_W)) u_lane (
    .word_in(m_rsp_rdata), .bitpos(bitpos_q), .set_val(wbit_q),
    .bit_out(lane_bit), .word_out(lane_word)
  );

  bb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_we(s_req_we),
    .s_req_wbit(s_req_wdata[0]), .acc_ok(acc_ok), .dec_baddr(dec_baddr),
    .dec_size(s_req_size), .dec_bitpos(dec_bitpos),
    .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
    .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_size(m_req_size), .m_req_we(m_req_we), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
    .lane_bit(lane_bit), .lane_word(lane_word),
    .bitpos_q(bitpos_q), .wbit_q(wbit_q)
  );

  // R8
  disabled_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req_valid && s_req_ready && !enable) |=> !m_req_valid);
endmodule

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        s_req_valid = 1'b0;
  logic        s_req_ready;
  logic [31:0] s_req_addr = '0;
  logic [2:0]  s_req_size = '0;
  logic        s_req_we = 1'b0;
  logic [31:0] s_req_wdata = '0;
  logic        s_rsp_valid;
  logic        s_rsp_ready = 1'b0;
  logic [31:0] s_rsp_rdata;
  logic        s_rsp_err;
  logic        m_req_valid;
  logic        m_req_ready = 1'b0;
  logic [31:0] m_req_addr;
  logic [2:0]  m_req_size;
  logic        m_req_we;
  logic [31:0] m_req_wdata;
  logic        m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_rdata = '0;
  logic        m_rsp_err = 1'b0;

  always #5 clk = ~clk;

  bitband_bridge i_bitband_bridge (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_addr(s_req_addr),
    .s_req_size(s_req_size), .s_req_we(s_req_we), .s_req_wdata(s_req_wdata),
    .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready), .s_rsp_rdata(s_rsp_rdata),
    .s_rsp_err(s_rsp_err),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_size(m_req_size), .m_req_we(m_req_we), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- backing memory model ----------------
  logic [7:0]  mem [logic [31:0]];
  int          acc_total = 0;
  logic [31:0] last_addr = '0;
  logic [2:0]  last_size = '0;
  logic        last_we = 1'b0;
  bit          inj_rd = 0;
  bit          inj_wr = 0;
  bit          pend = 0;
  logic [31:0] pdata = '0;
  logic        perr = 1'b0;

  function automatic logic [7:0] get_byte(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    m_rsp_valid = 1'b0;
    if (rst_n) begin
      if (pend) begin
        m_rsp_valid = 1'b1;
        m_rsp_rdata = pdata;
        m_rsp_err   = perr;
        pend        = 0;
        m_req_ready = 1'b0;
      end else begin
        m_req_ready = ($urandom_range(0, 2) != 0);
        if (m_req_valid && m_req_ready) begin
          acc_total++;
          last_addr = m_req_addr;
          last_size = m_req_size;
          last_we   = m_req_we;
          pdata     = '0;
          perr      = m_req_we ? inj_wr : inj_rd;
          for (int i = 0; i < int'(m_req_size) && i < 4; i++) begin
            if (m_req_we) begin
              if (!perr) mem[m_req_addr + 32'(i)] = m_req_wdata[8*i +: 8];
            end else begin
              pdata[8*i +: 8] = get_byte(m_req_addr + 32'(i));
            end
          end
          if (perr) pdata = 32'hDEAD_BEEF;
          pend = 1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    string       tag;
    logic        err;
    logic [31:0] rdata;
    int          nacc;
    logic [31:0] baddr;
    logic [2:0]  bsize;
    bit          chk_byte;
    logic [31:0] byte_addr;
    logic [7:0]  byte_val;
    int          acc_start;
  } exp_t;

  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n) begin
      s_rsp_ready = ($urandom_range(0, 3) != 0);
      if (s_rsp_valid && s_rsp_ready && exp_q.size() > 0) begin
        exp_t e;
        int n;
        e = exp_q.pop_front();
        n = acc_total - e.acc_start;
        chk(s_rsp_err == e.err, e.tag, "error flag", 32'(s_rsp_err), 32'(e.err));
        chk(s_rsp_rdata == e.rdata, e.tag, "rdata", s_rsp_rdata, e.rdata);
        chk(n == e.nacc, e.tag, "backing access count", 32'(n), 32'(e.nacc));
        if (e.nacc > 0) begin
          chk(last_addr == e.baddr, e.tag, "backing address", last_addr, e.baddr);
          chk(last_size == e.bsize, e.tag, "backing size", 32'(last_size), 32'(e.bsize));
        end
        if (e.nacc == 2)
          chk(last_we == 1'b1, e.tag, "last backing op is write", 32'(last_we), 32'd1);
        if (e.chk_byte)
          chk(get_byte(e.byte_addr) == e.byte_val, e.tag, "backing byte",
              32'(get_byte(e.byte_addr)), 32'(e.byte_val));
      end
    end
  end

  // reference mapping straight from the requirements
  task automatic ref_map(input logic [31:0] a, input logic [2:0] sz, output bit hit,
                         output logic [31:0] ba, output logic [31:0] bytea, output int bitn);
    logic [31:0] base;
    logic [31:0] off;
    int bp;
    hit = 1;
    if (a[31:25] == 7'h11) base = 32'h2000_0000;
    else if (a[31:25] == 7'h21) base = 32'h4000_0000;
    else begin hit = 0; base = '0; end
    off   = a & 32'h01FF_FFFF;
    ba    = (base | (off >> 5)) & ~(32'(sz) - 32'd1);
    bp    = int'((off >> 2) & (32'(sz) * 32'd8 - 32'd1));
    bytea = ba + 32'(bp >> 3);
    bitn  = bp & 7;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic [2:0] sz,
                        input bit we, input bit wb, input bit inj_r, input bit inj_w);
    exp_t e;
    bit hit, legal;
    logic [31:0] ba, bytea;
    int bitn;
    logic [7:0] old;
    ref_map(a, sz, hit, ba, bytea, bitn);
    legal = enable && hit && (sz == 3'd1 || sz == 3'd2 || sz == 3'd4);
    old   = get_byte(bytea);
    e.tag       = tag;
    e.nacc      = !legal ? 0 : (inj_r ? 1 : (we ? 2 : 1));
    e.err       = !legal || inj_r || (we && inj_w);
    e.rdata     = (legal && !inj_r && !we) ? 32'(old[bitn]) : 32'd0;
    e.baddr     = ba;
    e.bsize     = sz;
    e.chk_byte  = legal && we;
    e.byte_addr = bytea;
    e.byte_val  = (we && !inj_r && !inj_w) ?
                  (wb ? (old | (8'd1 << bitn)) : (old & ~(8'd1 << bitn))) : old;
    e.acc_start = acc_total;
    inj_rd = inj_r;
    inj_wr = inj_w;
    exp_q.push_back(e);
    @(negedge clk);
    s_req_valid = 1'b1;
    s_req_addr  = a;
    s_req_size  = sz;
    s_req_we    = we;
    s_req_wdata = {31'h2AAA_5555, wb};
    while (!s_req_ready) @(negedge clk);
    @(negedge clk);
    s_req_valid = 1'b0;
    chk(!s_req_ready || !exp_q.size(), "R9", "ready low while in flight", 32'(s_req_ready), 32'd0);
    while (exp_q.size() > 0) @(negedge clk);
    inj_rd = 0;
    inj_wr = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(s_req_ready == 1'b1, "R9", "reset ready", 32'(s_req_ready), 32'd1);
    chk(s_rsp_valid == 1'b0, "R9", "reset rsp valid", 32'(s_rsp_valid), 32'd0);
    chk(m_req_valid == 1'b0, "R9", "reset backing req", 32'(m_req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 reads of both windows at several sizes
    access("R1", 32'h2200_2034, 3'd4, 0, 0, 0, 0);
    access("R1", 32'h4206_8AF8, 3'd1, 0, 0, 0, 0);
    access("R3", 32'h2201_137C, 3'd2, 0, 0, 0, 0);
    access("R3", 32'h4200_0064, 3'd4, 0, 0, 0, 0);
    access("R2", 32'h2234_5678, 3'd4, 0, 0, 0, 0);
    access("R2", 32'h4234_567C, 3'd2, 0, 0, 0, 0);
    // R4 writes set and clear, then read back through the alias
    access("R4", 32'h2200_2034, 3'd4, 1, 1, 0, 0);
    access("R4", 32'h2200_2034, 3'd4, 0, 0, 0, 0);
    access("R4", 32'h4206_8AF8, 3'd1, 1, 0, 0, 0);
    access("R4", 32'h4206_8AF8, 3'd1, 0, 0, 0, 0);
    access("R4", 32'h2201_137C, 3'd2, 1, 1, 0, 0);
    access("R4", 32'h2201_1378, 3'd2, 1, 0, 0, 0);
    access("R4", 32'h2201_137C, 3'd2, 0, 0, 0, 0);
    // R1 top of each window
    access("R1", 32'h23FF_FFFC, 3'd4, 0, 0, 0, 0);
    access("R1", 32'h43FF_FFFF, 3'd1, 1, 1, 0, 0);
    // R7 illegal sizes and addresses outside both windows
    access("R7", 32'h2200_0010, 3'd3, 0, 0, 0, 0);
    access("R7", 32'h2200_0010, 3'd0, 1, 1, 0, 0);
    access("R7", 32'h2400_0000, 3'd4, 0, 0, 0, 0);
    access("R7", 32'h2000_0000, 3'd1, 1, 1, 0, 0);
    // R8 disabled bridge
    enable = 1'b0;
    access("R8", 32'h2200_2034, 3'd4, 0, 0, 0, 0);
    access("R8", 32'h4200_0064, 3'd4, 1, 0, 0, 0);
    enable = 1'b1;
    // R5 backing read error on read and on write
    access("R5", 32'h2200_0400, 3'd4, 0, 0, 1, 0);
    access("R5", 32'h2200_0400, 3'd4, 1, 1, 1, 0);
    // R6 backing write error
    access("R6", 32'h4200_0800, 3'd2, 1, 1, 0, 1);
    access("R6", 32'h4200_0800, 3'd2, 0, 0, 0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule